// File: doc/BRIEF.md
# Data trace message formatter

This block turns captured bus accesses into data trace messages. Each access that is traced produces one packed message. The message holds a transfer code, the source and size of the access, an address field and a data field. The address field comes in one of two forms. A sync message carries the whole address. A normal message carries only the bits that differ from a stored reference address. Leading zeros are stripped from both the address field and the data field, and the block reports the length of each.

The block decides when a message must take the sync form. The conditions are:
- reset release;
- a cycle in which tracing is off;
- leaving a low-power or debug mode;
- a gated event-in request;
- a blocked access to secure memory;
- an explicit request;
- a periodic count of normal messages.

Every sync message loads its full address as the new reference. A downstream serializer reads the packed vector together with the total bit count.

Top module: `dtrace_msg_fmt`

## Requirements
- R1: Bits 5:0 of each message hold the transfer code: 6'b001101 for a sync write, 6'b001110 for a sync read, 6'b000101 for a normal write and 6'b000110 for a normal read.
- R2: The packed message has the source in bits 9:6 and the size code in bits 12:10. The address field starts at bit 13 and takes address-length bits. The data field starts directly above the address field. All bits above the data field are zero.
- R3: The address length is the index of the highest set bit of the address field plus one, and is never less than 1. The data length is worked out the same way. The total length is 13 plus both lengths, so it always lies between 15 and 109.
- R4: A sync message carries the full access address and stores it as the reference. A normal message carries the XOR of the access address and the reference, and leaves the reference unchanged.
- R5: The first message after reset is a sync message.
- R6: An access made while trace_en is low produces no message. The first message after tracing is turned back on is a sync message.
- R7: A mode_exit pulse makes the next message a sync message. This applies whether the pulse comes in an earlier cycle or in the same cycle as the access.
- R8: An evt_in pulse forces sync only while both evt_allow and trace_en are high. Otherwise it has no effect on the next message.
- R9: An access with acc_secure high produces no message, and the next message is a sync message.
- R10: A force_sync pulse makes the next message a sync message.
- R11: After a sync message, up to PERIOD (default 255) normal messages may follow. The next message after that is forced to sync, and every sync message restarts this count.
- R12: The data field is masked to the access size before it is trimmed. Size codes 0, 1, 2 and 3 keep 8, 16, 32 and 64 bits. Codes 4 to 7 keep 64 bits.
- R13: msg_valid and every message field are registered. msg_valid is high for exactly the one cycle that follows each emitting access, and it is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trace_en | input | 1 | Data trace enable |
| evt_allow | input | 1 | Lets event-in requests force sync |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_addr | input | 32 | Access address |
| acc_data | input | 64 | Access data |
| acc_size | input | 3 | Size code |
| acc_src | input | 4 | Source identifier |
| acc_secure | input | 1 | Access targets secure memory |
| mode_exit | input | 1 | Leaving low-power or debug mode |
| evt_in | input | 1 | Event-in request |
| force_sync | input | 1 | Explicit sync request |
| msg_valid | output | 1 | Message present |
| msg_sync | output | 1 | Message is the sync form |
| msg_tcode | output | 6 | Transfer code |
| msg_addr | output | 32 | Address field |
| msg_addr_len | output | 6 | Address field length |
| msg_data | output | 64 | Masked data field |
| msg_data_len | output | 7 | Data field length |
| msg_len | output | 7 | Total message length in bits |
| msg_bits | output | 109 | Packed message, transfer code at bit 0 |

## Verification
Each message is due one clock after the edge that captures its access, so the bench drives inputs on a falling edge and samples at the next falling edge. By then the single output register has taken the result. A pulse given with no access only changes the internal pending flag, and the pulse-only cycle itself must show no message. The bench therefore confirms that effect through the sync form of the next access it drives. Because every check waits exactly one edge, the bench's model of the pending flag, the period count and the reference steps once per access, in the same order as the design.

// File: rtl/dtrace_msg_fmt.sv
module dtrace_msg_fmt #(
  parameter int AW = 32,
  parameter int DW = 64,
  parameter int PERIOD = 255,
  localparam int ALW = $clog2(AW + 1),
  localparam int DLW = $clog2(DW + 1),
  localparam int MW = 13 + AW + DW,
  localparam int LW = $clog2(MW + 1),
  localparam int CW = $clog2(PERIOD + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           trace_en,
  input  logic           evt_allow,
  input  logic           acc_valid,
  input  logic           acc_write,
  input  logic [AW-1:0]  acc_addr,
  input  logic [DW-1:0]  acc_data,
  input  logic [2:0]     acc_size,
  input  logic [3:0]     acc_src,
  input  logic           acc_secure,
  input  logic           mode_exit,
  input  logic           evt_in,
  input  logic           force_sync,
  output logic           msg_valid,
  output logic           msg_sync,
  output logic [5:0]     msg_tcode,
  output logic [AW-1:0]  msg_addr,
  output logic [ALW-1:0] msg_addr_len,
  output logic [DW-1:0]  msg_data,
  output logic [DLW-1:0] msg_data_len,
  output logic [LW-1:0]  msg_len,
  output logic [MW-1:0]  msg_bits
);

  function automatic logic [ALW-1:0] addr_width(input logic [AW-1:0] v);
    int n = 1;
    for (int i = 0; i < AW; i++) if (v[i]) n = i + 1;
    return ALW'(n);
  endfunction

  function automatic logic [DLW-1:0] data_width(input logic [DW-1:0] v);
    int n = 1;
    for (int i = 0; i < DW; i++) if (v[i]) n = i + 1;
    return DLW'(n);
  endfunction

  function automatic logic [DW-1:0] size_mask(input logic [2:0] s);
    int w = 8 << s;
    if (w >= DW) return '1;
    return (DW'(1) << w) - DW'(1);
  endfunction

  logic          sync_pend;
  logic [CW-1:0] per_cnt;
  logic [AW-1:0] ref_addr;

  logic           emit, force_now, set_now, is_sync;
  logic [AW-1:0]  addr_fld;
  logic [DW-1:0]  data_fld;
  logic [ALW-1:0] alen;
  logic [DLW-1:0] dlen;
  logic [5:0]     tcode;
  logic [MW-1:0]  packed_msg;

  assign emit      = acc_valid & trace_en & ~acc_secure;
  assign force_now = mode_exit | (evt_in & evt_allow & trace_en) | force_sync;
  assign set_now   = force_now | ~trace_en | (acc_valid & acc_secure);
  assign is_sync   = sync_pend | force_now | (per_cnt == CW'(PERIOD));

  assign addr_fld = is_sync ? acc_addr : (acc_addr ^ ref_addr);
  assign data_fld = acc_data & size_mask(acc_size);
  assign alen     = addr_width(addr_fld);
  assign dlen     = data_width(data_fld);
  assign tcode    = {2'b00, is_sync, 1'b1, acc_write ? 2'b01 : 2'b10};

  assign packed_msg = MW'(tcode)
                    | (MW'(acc_src) << 6)
                    | (MW'(acc_size) << 10)
                    | (MW'(addr_fld) << 13)
                    | (MW'(data_fld) << (13 + int'(alen)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_pend <= 1'b1;
      per_cnt   <= '0;
      ref_addr  <= '0;
    end else if (emit && is_sync) begin
      sync_pend <= 1'b0;
      per_cnt   <= '0;
      ref_addr  <= acc_addr;
    end else begin
      sync_pend <= sync_pend | set_now;
      if (emit) per_cnt <= per_cnt + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid    <= 1'b0;
      msg_sync     <= 1'b0;
      msg_tcode    <= '0;
      msg_addr     <= '0;
      msg_addr_len <= '0;
      msg_data     <= '0;
      msg_data_len <= '0;
      msg_len      <= '0;
      msg_bits     <= '0;
    end else begin
      msg_valid <= emit;
      if (emit) begin
        msg_sync     <= is_sync;
        msg_tcode    <= tcode;
        msg_addr     <= addr_fld;
        msg_addr_len <= alen;
        msg_data     <= data_fld;
        msg_data_len <= dlen;
        msg_len      <= LW'(13 + int'(alen) + int'(dlen));
        msg_bits     <= packed_msg;
      end
    end
  end

endmodule

module dtrace_msg_fmt_chk #(
  parameter int AW = 32,
  parameter int DW = 64,
  parameter int PERIOD = 255,
  parameter int ALW = 6,
  parameter int DLW = 7,
  parameter int LW = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic           trace_en,
  input logic           acc_valid,
  input logic [AW-1:0]  acc_addr,
  input logic           acc_secure,
  input logic           mode_exit,
  input logic           msg_valid,
  input logic           msg_sync,
  input logic [5:0]     msg_tcode,
  input logic [AW-1:0]  msg_addr,
  input logic [ALW-1:0] msg_addr_len,
  input logic [DLW-1:0] msg_data_len,
  input logic [LW-1:0]  msg_len
);
  logic seen;
  int   norm_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen     <= 1'b0;
      norm_cnt <= 0;
    end else if (msg_valid) begin
      seen     <= 1'b1;
      norm_cnt <= msg_sync ? 0 : norm_cnt + 1;
    end
  end

  a_r1_tcode: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_tcode[5:4] == 2'b00 && msg_tcode[2] && msg_tcode[3] == msg_sync
                   && (msg_tcode[1:0] == 2'b01 || msg_tcode[1:0] == 2'b10)));

  a_r3_length: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_addr_len >= 1 && msg_data_len >= 1
                   && int'(msg_len) == 13 + int'(msg_addr_len) + int'(msg_data_len)
                   && msg_len >= 15 && int'(msg_len) <= 13 + AW + DW));

  a_r4_sync_full_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && trace_en && !acc_secure) |=> (msg_valid && (!msg_sync || msg_addr == $past(acc_addr))));

  a_r5_first_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !seen) |-> msg_sync);

  a_r6_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !trace_en |=> !msg_valid);

  a_r7_mode_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && trace_en && !acc_secure && mode_exit) |=> (msg_valid && msg_sync));

  a_r9_secure: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_secure) |=> !msg_valid);

  a_r11_period: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_sync) |-> norm_cnt < PERIOD);
endmodule

bind dtrace_msg_fmt dtrace_msg_fmt_chk #(
  .AW(AW), .DW(DW), .PERIOD(PERIOD), .ALW(ALW), .DLW(DLW), .LW(LW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .acc_valid(acc_valid),
  .acc_addr(acc_addr), .acc_secure(acc_secure), .mode_exit(mode_exit),
  .msg_valid(msg_valid), .msg_sync(msg_sync), .msg_tcode(msg_tcode),
  .msg_addr(msg_addr), .msg_addr_len(msg_addr_len),
  .msg_data_len(msg_data_len), .msg_len(msg_len)
);

// File: tb/dtrace_msg_fmt_tb_top.sv
module dtrace_msg_fmt_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trace_en = 1'b1, evt_allow = 1'b0;
  logic acc_valid = 1'b0, acc_write = 1'b0, acc_secure = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [63:0] acc_data = '0;
  logic [2:0] acc_size = '0;
  logic [3:0] acc_src = '0;
  logic mode_exit = 1'b0, evt_in = 1'b0, force_sync = 1'b0;
  logic msg_valid, msg_sync;
  logic [5:0] msg_tcode;
  logic [31:0] msg_addr;
  logic [5:0] msg_addr_len;
  logic [63:0] msg_data;
  logic [6:0] msg_data_len, msg_len;
  logic [108:0] msg_bits;

  int checks = 0, fails = 0;
  bit m_pend = 1'b1;
  int m_cnt = 0;
  logic [31:0] m_ref = '0;

  always #5 clk = ~clk;

  dtrace_msg_fmt dut_i (
    .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .evt_allow(evt_allow),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
    .acc_data(acc_data), .acc_size(acc_size), .acc_src(acc_src),
    .acc_secure(acc_secure), .mode_exit(mode_exit), .evt_in(evt_in),
    .force_sync(force_sync), .msg_valid(msg_valid), .msg_sync(msg_sync),
    .msg_tcode(msg_tcode), .msg_addr(msg_addr), .msg_addr_len(msg_addr_len),
    .msg_data(msg_data), .msg_data_len(msg_data_len), .msg_len(msg_len),
    .msg_bits(msg_bits)
  );

  task automatic check(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int hibits(input logic [63:0] v);
    int n = 1;
    for (int i = 0; i < 64; i++) if (v[i]) n = i + 1;
    return n;
  endfunction

  task automatic pulse(input bit mx, input bit ev, input bit fs);
    @(negedge clk);
    mode_exit = mx; evt_in = ev; force_sync = fs;
    @(negedge clk);
    mode_exit = 0; evt_in = 0; force_sync = 0;
    check("R13", "valid after pulse only", 128'(msg_valid), 128'(0));
    if (mx || fs || (ev && evt_allow && trace_en) || !trace_en) m_pend = 1'b1;
  endtask

  task automatic access(input string req, input bit wr, input logic [31:0] a, input logic [63:0] d,
                        input logic [2:0] sz, input logic [3:0] src,
                        input bit sec, input bit mx, input bit ev, input bit fs);
    bit emit, fnow, sync;
    logic [31:0] af;
    logic [63:0] df;
    int al, dl, w;
    logic [127:0] eb;
    @(negedge clk);
    acc_valid = 1; acc_write = wr; acc_addr = a; acc_data = d; acc_size = sz; acc_src = src;
    acc_secure = sec; mode_exit = mx; evt_in = ev; force_sync = fs;
    emit = trace_en && !sec;
    fnow = mx || (ev && evt_allow && trace_en) || fs;
    sync = m_pend || fnow || (m_cnt == 255);
    af = sync ? a : (a ^ m_ref);
    w = 8 << sz;
    df = (w >= 64) ? d : (d & ((64'd1 << w) - 64'd1));
    al = hibits({32'd0, af});
    dl = hibits(df);
    @(negedge clk);
    acc_valid = 0; acc_secure = 0; mode_exit = 0; evt_in = 0; force_sync = 0;
    check("R13", "msg_valid", 128'(msg_valid), 128'(emit));
    if (emit) begin
      check(req, "sync form", 128'(msg_sync), 128'(sync));
      check("R1", "tcode", 128'(msg_tcode), 128'({2'b00, sync, 1'b1, wr ? 2'b01 : 2'b10}));
      check("R4", "address field", 128'(msg_addr), 128'(af));
      check("R12", "data field", 128'(msg_data), 128'(df));
      check("R3", "lengths", 128'({msg_addr_len, msg_data_len, msg_len}),
            128'({6'(al), 7'(dl), 7'(13 + al + dl)}));
      eb = 128'({sync ? 2'b00 : 2'b00, sync, 1'b1, wr ? 2'b01 : 2'b10})
         | (128'(src) << 6) | (128'(sz) << 10) | (128'(af) << 13) | (128'(df) << (13 + al));
      check("R2", "packed bits", 128'(msg_bits), eb);
      if (sync) begin m_pend = 0; m_cnt = 0; m_ref = a; end
      else m_cnt++;
    end else m_pend = 1'b1;
    if (!trace_en) m_pend = 1'b1;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R13", "reset valid", 128'(msg_valid), 128'(0));
    check("R13", "reset length", 128'(msg_len), 128'(0));
    rst_n = 1;
    // R5 first message after reset
    access("R5", 1, 32'h8000_1234, 64'hAB, 3'd0, 4'h3, 0, 0, 0, 0);
    // R4 and R3: relative address sweep across each bit
    for (int i = 0; i < 32; i++)
      access("R4", i[0], 32'h8000_1234 ^ (32'd1 << i), 64'h1 << (i % 8), 3'd3, 4'(i), 0, 0, 0, 0);
    // R12 size sweep with full data
    for (int s = 0; s < 8; s++) begin
      access("R12", 1, 32'h8000_1230 + 32'(s), 64'hFFFF_FFFF_FFFF_FFFF, 3'(s), 4'h5, 0, 0, 0, 0);
      access("R12", 0, 32'h8000_1240, 64'h0, 3'(s), 4'hA, 0, 0, 0, 0);
    end
    // R6 trace disabled
    trace_en = 0;
    access("R6", 1, 32'h1000, 64'h55, 3'd1, 4'h1, 0, 0, 0, 0);
    trace_en = 1;
    access("R6", 1, 32'h1004, 64'h55, 3'd1, 4'h1, 0, 0, 0, 0);
    access("R6", 0, 32'h1008, 64'h66, 3'd1, 4'h1, 0, 0, 0, 0);
    // R7 mode exit earlier and same cycle
    pulse(1, 0, 0);
    access("R7", 0, 32'h2000, 64'h1, 3'd2, 4'h2, 0, 0, 0, 0);
    access("R7", 1, 32'h2010, 64'h1, 3'd2, 4'h2, 0, 0, 0, 0);
    access("R7", 1, 32'h2020, 64'h1, 3'd2, 4'h2, 0, 1, 0, 0);
    // R8 event gating
    evt_allow = 0;
    pulse(0, 1, 0);
    access("R8", 1, 32'h3000, 64'h7, 3'd0, 4'h4, 0, 0, 0, 0);
    access("R8", 1, 32'h3004, 64'h7, 3'd0, 4'h4, 0, 0, 1, 0);
    evt_allow = 1;
    pulse(0, 1, 0);
    access("R8", 0, 32'h3008, 64'h7, 3'd0, 4'h4, 0, 0, 0, 0);
    access("R8", 0, 32'h300C, 64'h7, 3'd0, 4'h4, 0, 0, 1, 0);
    evt_allow = 0;
    // R9 secure access
    access("R9", 1, 32'hF000_0000, 64'h9, 3'd3, 4'h6, 1, 0, 0, 0);
    access("R9", 1, 32'h4000, 64'h9, 3'd3, 4'h6, 0, 0, 0, 0);
    // R10 explicit request
    pulse(0, 0, 1);
    access("R10", 0, 32'h5000, 64'h3, 3'd1, 4'h7, 0, 0, 0, 0);
    access("R10", 0, 32'h5004, 64'h3, 3'd1, 4'h7, 0, 0, 0, 1);
    // R11 periodic sync: 255 normal messages then sync
    for (int k = 0; k < 300; k++)
      access("R11", k[1], 32'h6000 + 32'(k * 4), 64'(k * 37), 3'(k % 4), 4'(k), 0, 0, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule